// File: doc/BRIEF.md
# Multi-Class Bus Address Decoder

This block sits behind the bit-level engine of a PMBus/SMBus-style serial port. It decides whether the address byte of a new transaction is meant for this device. It also decides which output channels the command that follows may touch. One port answers at several addresses at once:

- a fixed broadcast address that reaches every channel;
- a fixed paged broadcast address that reaches the channel chosen by PAGE;
- a programmable device address, built from a select-pin code and a register;
- a programmable group address that each channel holds for itself.

The serial engine presents the 7-bit address and the read/write bit with a one-cycle `addr_valid` strobe. One cycle later the block returns:

- `ack`, a one-cycle acknowledge pulse;
- `ch_mask`, the per-channel write enable that goes with the acknowledge;
- `rd_bcast_flag`, a sticky flag that records a read attempted at a broadcast or group address.

The PAGE, device-address and group-address registers are kept inside the block. The command path writes them through a small config port.

Top module: `bus_addr_decoder`

## Requirements
- R1: After reset, `ack`, `ch_mask` and `rd_bcast_flag` are 0, PAGE is 0x00, the device register holds 0x40 and every group register holds 0x80 (disabled).
- R2: A write at 0x5A is acknowledged and sets every channel bit in `ch_mask`, whatever PAGE holds. Both outputs appear in the cycle after `addr_valid`.
- R3: A write at 0x5B is acknowledged, and its `ch_mask` equals the PAGE mask.
- R4: The PAGE mask is bit 0 for PAGE 0x00, bit 1 for PAGE 0x01 and all bits for PAGE 0xFF. Any other PAGE value gives an empty mask, and the acknowledge is still given.
- R5: The device address is {device register bits 6:3, pin code bits 2:0}. A read or a write there is acknowledged with the PAGE mask. Changing the pin code moves the address.
- R6: A device register value with bit 7 set (for example 0x80) disables the device address.
- R7: A config write with select 2 loads the group register of every channel in the PAGE mask. A group register with bit 7 clear makes its low 7 bits an address that sets that channel's bit on a write. Bit 7 set disables that channel's group address.
- R8: A read at 0x5A, at 0x5B or at an enabled group address is not acknowledged unless the address is also the device address. Such a read sets `rd_bcast_flag`, which stays set until reset.
- R9: When several address classes match one write, their channel masks are OR-combined under a single acknowledge.
- R10: An address that matches no class, or a cycle without `addr_valid`, gives `ack` 0 and `ch_mask` 0. The config select codes are 0 for PAGE, 1 for the device register and 2 for group registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_sel | input | PIN_W | Address-select pin code |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Config target: 0 PAGE, 1 device, 2 group |
| cfg_data | input | 8 | Config write data |
| addr_valid | input | 1 | Address byte strobe |
| addr | input | 7 | 7-bit bus address |
| rd | input | 1 | Read (1) or write (0) |
| ack | output | 1 | Address acknowledge pulse |
| ch_mask | output | NCH | Channels the command may write |
| rd_bcast_flag | output | 1 | Sticky: read at a broadcast or group address |

## Verification
The hardest case to reach is an overlap, where one address hits the device class and a group class at once. To build it, the bench gives the two channels different group addresses through two paged config writes. It then sets the device register and pin code so that the device address equals one channel's group address, with PAGE naming the other channel. Only an OR of both classes yields both bits. Because the read flag is sticky, the bench resets in the middle of the run, so that it can see the flag set first by a group read and later by a paged-broadcast read.

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder #(
  parameter int          NCH        = 2,
  parameter int          PIN_W      = 3,
  parameter logic [6:0]  BCAST_ADDR = 7'h5A,
  parameter logic [6:0]  PAGED_ADDR = 7'h5B,
  parameter logic [7:0]  DEV_INIT   = 8'h40,
  parameter logic [7:0]  RAIL_INIT  = 8'h80,
  parameter logic [7:0]  PAGE_ALL   = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_sel,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [7:0]       cfg_data,
  input  logic             addr_valid,
  input  logic [6:0]       addr,
  input  logic             rd,
  output logic             ack,
  output logic [NCH-1:0]   ch_mask,
  output logic             rd_bcast_flag
);
  localparam logic [1:0] SEL_PAGE = 2'd0;
  localparam logic [1:0] SEL_DEV  = 2'd1;
  localparam logic [1:0] SEL_RAIL = 2'd2;

  logic [7:0]     page_q, dev_q;
  logic [7:0]     rail_q [NCH];
  logic [NCH-1:0] page_mask, rail_hit, wr_mask, nxt_mask;

  always_comb begin
    page_mask = '0;
    if (page_q == PAGE_ALL) page_mask = '1;
    else
      for (int c = 0; c < NCH; c++)
        page_mask[c] = (page_q == 8'(c));
  end

  wire [6:0] dev_addr = {dev_q[6:PIN_W], pin_sel};
  wire hit_g   = (addr == BCAST_ADDR);
  wire hit_pg  = (addr == PAGED_ADDR);
  wire hit_dev = !dev_q[7] && (addr == dev_addr);

  for (genvar c = 0; c < NCH; c++) begin : g_rail
    assign rail_hit[c] = !rail_q[c][7] && (rail_q[c][6:0] == addr);
    always_ff @(posedge clk)
      if (!rst_n) rail_q[c] <= RAIL_INIT;
      else if (cfg_we && cfg_sel == SEL_RAIL && page_mask[c]) rail_q[c] <= cfg_data;
  end

  wire bc_hit  = hit_g || hit_pg || (|rail_hit);
  assign wr_mask  = {NCH{hit_g}} | (hit_pg ? page_mask : '0)
                  | (hit_dev ? page_mask : '0) | rail_hit;
  assign nxt_mask = rd ? (hit_dev ? page_mask : '0) : wr_mask;
  wire nxt_ack = rd ? hit_dev : (bc_hit || hit_dev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= 8'h00;
      dev_q  <= DEV_INIT;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_PAGE) page_q <= cfg_data;
      if (cfg_sel == SEL_DEV)  dev_q  <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack           <= 1'b0;
      ch_mask       <= '0;
      rd_bcast_flag <= 1'b0;
    end else begin
      ack     <= addr_valid && nxt_ack;
      ch_mask <= addr_valid ? nxt_mask : '0;
      if (addr_valid && rd && bc_hit) rd_bcast_flag <= 1'b1;
    end
  end
endmodule

module bus_addr_decoder_chk #(
  parameter int         NCH        = 2,
  parameter logic [6:0] BCAST_ADDR = 7'h5A,
  parameter logic [6:0] PAGED_ADDR = 7'h5B
) (
  input logic           clk,
  input logic           rst_n,
  input logic           addr_valid,
  input logic [6:0]     addr,
  input logic           rd,
  input logic           ack,
  input logic [NCH-1:0] ch_mask,
  input logic           rd_bcast_flag
);
  assert_bcast_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !rd && addr == BCAST_ADDR |=> ack && ch_mask == {NCH{1'b1}});

  assert_paged_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !rd && addr == PAGED_ADDR |=> ack);

  assert_bcast_read_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && rd && (addr == BCAST_ADDR || addr == PAGED_ADDR) |=> rd_bcast_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bcast_flag |=> rd_bcast_flag);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !ack && ch_mask == '0);

  assert_mask_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_mask) |-> ack);
endmodule

bind bus_addr_decoder bus_addr_decoder_chk #(
  .NCH(NCH), .BCAST_ADDR(BCAST_ADDR), .PAGED_ADDR(PAGED_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr), .rd(rd),
  .ack(ack), .ch_mask(ch_mask), .rd_bcast_flag(rd_bcast_flag)
);

// File: tb/bus_addr_decoder_test.sv
module bus_addr_decoder_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] pin_sel = 3'd5;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_data = 8'h00;
  logic       addr_valid = 1'b0;
  logic [6:0] addr = 7'h00;
  logic       rd = 1'b0;
  logic       ack, rd_bcast_flag;
  logic [1:0] ch_mask;

  bus_addr_decoder uut (
    .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .addr_valid(addr_valid), .addr(addr), .rd(rd),
    .ack(ack), .ch_mask(ch_mask), .rd_bcast_flag(rd_bcast_flag)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic       ack;
    logic [1:0] mask;
    logic       flag;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic vd = 1'b0;
  bit done = 0;

  logic [7:0] m_page, m_dev;
  logic [7:0] m_rail [2];
  logic       m_flag;

  function automatic logic [1:0] pmask();
    if (m_page == 8'hFF) return 2'b11;
    if (m_page == 8'h00) return 2'b01;
    if (m_page == 8'h01) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_page = 8'h00; m_dev = 8'h40; m_rail[0] = 8'h80; m_rail[1] = 8'h80; m_flag = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    if (sel == 2'd0) m_page = d;
    if (sel == 2'd1) m_dev = d;
    if (sel == 2'd2) begin
      if (pmask()[0]) m_rail[0] = d;
      if (pmask()[1]) m_rail[1] = d;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [6:0] a, input logic r, input string req);
    exp_t e;
    logic hg, hp, hd;
    logic [1:0] rh, wm;
    hg = (a == 7'h5A);
    hp = (a == 7'h5B);
    hd = !m_dev[7] && a == {m_dev[6:3], pin_sel};
    for (int c = 0; c < 2; c++) rh[c] = !m_rail[c][7] && m_rail[c][6:0] == a;
    wm = (hg ? 2'b11 : 2'b00) | ((hp || hd) ? pmask() : 2'b00) | rh;
    if (r) begin
      e.ack  = hd;
      e.mask = hd ? pmask() : 2'b00;
      if (hg || hp || (|rh)) m_flag = 1'b1;
    end else begin
      e.ack  = hg || hp || hd || (|rh);
      e.mask = wm;
    end
    e.flag = m_flag;
    e.req  = req;
    @(negedge clk);
    q.push_back(e);
    addr_valid = 1'b1; addr = a; rd = r;
    @(negedge clk);
    addr_valid = 1'b0; rd = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) vd <= addr_valid;

  always @(negedge clk) begin
    if (rst_n && vd) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=ack%b expected=nothing", ack);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, {ack, ch_mask, rd_bcast_flag}, {e.ack, e.mask, e.flag});
      end
    end else if (rst_n && (ack || ch_mask != 2'b00)) begin
      chk("R10 idle", {ack, ch_mask, 1'b0}, 4'b0000);
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 reset outputs", {ack, ch_mask, rd_bcast_flag}, 4'b0000);
    send(7'h45, 1'b0, "R1 R5 default device write");
    send(7'h45, 1'b1, "R5 device read");
    send(7'h00, 1'b0, "R1 R7 group disabled at reset");
    send(7'h5A, 1'b0, "R2 broadcast page0");
    send(7'h5B, 1'b0, "R3 paged page0");
    cfg(2'd0, 8'h01);
    send(7'h5B, 1'b0, "R3 R4 paged page1");
    send(7'h5A, 1'b0, "R2 broadcast page1");
    cfg(2'd0, 8'hFF);
    send(7'h5B, 1'b0, "R4 paged page FF");
    cfg(2'd0, 8'h07);
    send(7'h5B, 1'b0, "R4 paged page out of range");
    send(7'h45, 1'b0, "R4 device page out of range");
    send(7'h33, 1'b0, "R10 no match");
    pin_sel = 3'd3;
    send(7'h43, 1'b0, "R5 pin moved address");
    send(7'h45, 1'b0, "R5 old address dropped");
    cfg(2'd1, 8'h80);
    send(7'h43, 1'b0, "R6 device disabled");
    send(7'h43, 1'b1, "R6 device read disabled");
    cfg(2'd0, 8'h00);
    cfg(2'd2, 8'h30);
    cfg(2'd0, 8'h01);
    cfg(2'd2, 8'h35);
    send(7'h30, 1'b0, "R7 group ch0");
    send(7'h35, 1'b0, "R7 group ch1");
    send(7'h35, 1'b1, "R8 group read refused");
    send(7'h5A, 1'b1, "R8 flag stays set");
    cfg(2'd1, 8'h30);
    pin_sel = 3'd0;
    send(7'h30, 1'b0, "R9 device plus group OR");
    cfg(2'd0, 8'hFF);
    cfg(2'd2, 8'h30);
    send(7'h30, 1'b0, "R7 R9 both groups share address");
    cfg(2'd0, 8'h00);
    cfg(2'd2, 8'h80);
    cfg(2'd1, 8'h80);
    send(7'h30, 1'b0, "R7 ch0 group disabled");
    do_reset();
    @(negedge clk);
    chk("R1 R8 flag cleared by reset", {ack, ch_mask, rd_bcast_flag}, 4'b0000);
    send(7'h5B, 1'b1, "R8 paged read refused");
    send(7'h5A, 1'b1, "R8 broadcast read refused");
    repeat (3) @(negedge clk);
    if (q.size() != 0) chk("scoreboard drained", 4'(q.size()), 4'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule